// File: doc/BRIEF.md
# E1 Receiver Automatic Alarm Controller

This block holds the hardware reactions that an E1 framer receiver takes by itself when its line or framing state changes, so that no processor has to step in. From the synchronizer state (frame alignment lost or held), loss of signal, loss of CAS multiframe alignment, receive slip pulses and the CRC results of received submultiframes, it drives five controls:

- the remote-alarm bit sent by the transmitter
- the two E-bit values of the outgoing CRC multiframe
- a select that forces AIS onto the receive system interface
- the clock-source mode (slave or master)
- a freeze control for the received signaling buffer

Each reaction has its own enable or disable bit in a 5-bit configuration word. Every output is a register that moves only on the frame strobe, so the transmitter and the system interface see changes only at frame boundaries. Freeze is held until the triggers are gone and one whole CAS multiframe (`MF_FRAMES` frames) has been received without a trigger.

Top module: `e1_auto_alarm`

## Requirements
- R1: With `cfg[0]` (remote-alarm enable) set, a frame strobe that sees `lfa` high sets `tx_ra`, and a strobe that sees `lfa` low clears it. With `cfg[0]` clear, strobes drive `tx_ra` to 0.
- R2: A strobe drives `ais_force` to 1 when `lfa` is high and `cfg[2]` (AIS disable) is clear. Otherwise it drives `ais_force` to 0, so received data passes through.
- R3: A strobe drives `clk_master` to 1 (master) when `los` is high and `cfg[3]` (switch disable) is clear. Otherwise it drives `clk_master` to 0 (slave, following the line clock).
- R4: With `cfg[1]` (automatic E-bit) set, a `smf_done` pulse stores a report for submultiframe `smf_idx`: 1 when `smf_crc_ok` is high, 0 on a CRC error. The next strobe that has `tx_mf_start` high puts the report on `tx_ebit[smf_idx]` and consumes it. A slot with no pending report is sent as 1.
- R5: With `cfg[1]` clear, a strobe with `tx_mf_start` drives `tx_ebit` to 2'b11.
- R6: A strobe that sees `los` or `cas_lma` high sets `sig_freeze`, unless `cfg[4]` (freeze disable) is set.
- R7: A `slip_evt` pulse that falls between two strobes is remembered and sets `sig_freeze` at the next strobe.
- R8: Once set, `sig_freeze` clears on the `MF_FRAMES`-th consecutive strobe that sees no trigger. A trigger seen at any strobe restarts that count.
- R9: With `cfg[4]` set, every strobe drives `sig_freeze` to 0, whatever the triggers are.
- R10: After reset `tx_ra`, `ais_force`, `clk_master` and `sig_freeze` are 0 and `tx_ebit` is 2'b11. No output changes in a cycle without `frm_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_stb | input | 1 | One-cycle strobe at each frame boundary |
| tx_mf_start | input | 1 | Together with `frm_stb`: the outgoing CRC multiframe starts |
| lfa | input | 1 | Frame alignment lost |
| los | input | 1 | Loss of signal |
| cas_lma | input | 1 | CAS multiframe alignment lost |
| slip_evt | input | 1 | Receive slip pulse |
| smf_done | input | 1 | A received submultiframe has finished |
| smf_idx | input | 1 | Index of the finished submultiframe |
| smf_crc_ok | input | 1 | CRC result of the finished submultiframe |
| cfg | input | 5 | [0] RA enable, [1] E-bit enable, [2] AIS disable, [3] clock switch disable, [4] freeze disable |
| tx_ra | output | 1 | Remote-alarm bit for the transmitter |
| tx_ebit | output | 2 | E-bits for the outgoing multiframe, bit i for submultiframe i |
| ais_force | output | 1 | Force all-ones AIS onto the receive system data |
| clk_master | output | 1 | 1 = master clock source, 0 = slave |
| sig_freeze | output | 1 | Hold the received signaling buffer |

## Verification
The hardest case to reach is the end of the freeze hold. It needs a long run of trigger-free strobes, and a trigger that lands part way through the run must start the count again. The bench drives exactly `MF_FRAMES`-1 clean strobes and checks that freeze still holds, then one more and checks that it drops. A second run puts a single `cas_lma` frame in the middle of the count. A slip pulse between strobes and E-bit reports that arrive away from the multiframe strobe cover the other paths where an event has to be stored before the strobe uses it.

// File: rtl/e1aa_pkg.sv
package e1aa_pkg;

  typedef struct packed {
    logic freeze_dis;
    logic clksw_dis;
    logic ais_dis;
    logic ebit_en;
    logic ra_en;
  } e1aa_cfg_t;

  // value sent in an E-bit slot: a pending report, otherwise "no error"
  function automatic logic ebit_value(input logic valid, input logic crc_ok);
    return valid ? crc_ok : 1'b1;
  endfunction

  // next value of the clean-frame counter during a freeze hold
  function automatic int unsigned clean_next(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1 >= limit) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/e1aa_level_react.sv
module e1aa_level_react (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic lfa,
  input  logic los,
  input  logic ra_en,
  input  logic ais_dis,
  input  logic clksw_dis,
  output logic ra,
  output logic ais,
  output logic master
);

  logic ra_d, ais_d, master_d;

  always_comb begin
    ra_d     = ra_en & lfa;
    ais_d    = lfa & ~ais_dis;
    master_d = los & ~clksw_dis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra     <= 1'b0;
      ais    <= 1'b0;
      master <= 1'b0;
    end else if (stb) begin
      ra     <= ra_d;
      ais    <= ais_d;
      master <= master_d;
    end
  end

  assert_ra_follows_lfa_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (ra == ($past(lfa) & $past(ra_en))));
  assert_ais_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && lfa && !ais_dis) |=> ais);
  assert_clk_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && clksw_dis) |=> !master);
  assert_hold_between_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(ra) && $stable(ais) && $stable(master)));

endmodule

// File: rtl/e1aa_ebit_queue.sv
module e1aa_ebit_queue
  import e1aa_pkg::*;
#(
  parameter int unsigned N_SMF = 2,
  localparam int unsigned IDX_W = (N_SMF > 1) ? $clog2(N_SMF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             mf_start,
  input  logic             en,
  input  logic             rpt_valid,
  input  logic [IDX_W-1:0] rpt_idx,
  input  logic             rpt_ok,
  output logic [N_SMF-1:0] ebit
);

  logic [N_SMF-1:0] pend_v;
  logic [N_SMF-1:0] pend_ok;
  logic             consume;

  assign consume = stb & mf_start;

  for (genvar i = 0; i < N_SMF; i++) begin : g_slot
    logic wr;
    assign wr = rpt_valid & (rpt_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_v[i]  <= 1'b0;
        pend_ok[i] <= 1'b1;
        ebit[i]    <= 1'b1;
      end else begin
        if (wr) begin
          pend_v[i]  <= 1'b1;
          pend_ok[i] <= rpt_ok;
        end else if (consume) begin
          pend_v[i] <= 1'b0;
        end
        if (consume)
          ebit[i] <= en ? ebit_value(pend_v[i], pend_ok[i]) : 1'b1;
      end
    end

    assert_report_sent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && en && pend_v[i] && !pend_ok[i]) |=> !ebit[i]);
  end

  assert_disabled_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !en) |=> (ebit == {N_SMF{1'b1}}));
  assert_ebit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !consume |=> $stable(ebit));

endmodule

// File: rtl/e1aa_freeze_ctl.sv
module e1aa_freeze_ctl
  import e1aa_pkg::*;
#(
  parameter int unsigned MF_FRAMES = 16,
  localparam int unsigned CNT_W = $clog2(MF_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic los,
  input  logic cas_lma,
  input  logic slip_evt,
  input  logic dis,
  output logic trig,
  output logic freeze
);

  logic             slip_pend;
  logic [CNT_W-1:0] clean_cnt;
  logic             release_now;

  assign trig        = los | cas_lma | slip_pend | slip_evt;
  assign release_now = (32'(clean_cnt) + 1 >= MF_FRAMES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slip_pend <= 1'b0;
    else if (stb) slip_pend <= 1'b0;
    else if (slip_evt) slip_pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze    <= 1'b0;
      clean_cnt <= '0;
    end else if (stb) begin
      if (dis) begin
        freeze    <= 1'b0;
        clean_cnt <= '0;
      end else if (trig) begin
        freeze    <= 1'b1;
        clean_cnt <= '0;
      end else if (freeze) begin
        clean_cnt <= CNT_W'(clean_next(32'(clean_cnt), MF_FRAMES));
        if (release_now) freeze <= 1'b0;
      end
    end
  end

  assert_freeze_on_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !dis && (los || cas_lma)) |=> freeze);
  assert_slip_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && slip_evt) |=> slip_pend);
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(clean_cnt) < MF_FRAMES);
  assert_freeze_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && dis) |=> !freeze);
  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(freeze));

endmodule

// File: rtl/e1_auto_alarm.sv
module e1_auto_alarm
  import e1aa_pkg::*;
#(
  parameter int unsigned MF_FRAMES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_stb,
  input  logic       tx_mf_start,
  input  logic       lfa,
  input  logic       los,
  input  logic       cas_lma,
  input  logic       slip_evt,
  input  logic       smf_done,
  input  logic       smf_idx,
  input  logic       smf_crc_ok,
  input  logic [4:0] cfg,
  output logic       tx_ra,
  output logic [1:0] tx_ebit,
  output logic       ais_force,
  output logic       clk_master,
  output logic       sig_freeze
);

  e1aa_cfg_t c;
  logic      freeze_trig;

  assign c = e1aa_cfg_t'(cfg);

  e1aa_level_react u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (frm_stb),
    .lfa      (lfa),
    .los      (los),
    .ra_en    (c.ra_en),
    .ais_dis  (c.ais_dis),
    .clksw_dis(c.clksw_dis),
    .ra       (tx_ra),
    .ais      (ais_force),
    .master   (clk_master)
  );

  e1aa_ebit_queue #(.N_SMF(2)) u_ebit (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (frm_stb),
    .mf_start (tx_mf_start),
    .en       (c.ebit_en),
    .rpt_valid(smf_done),
    .rpt_idx  (smf_idx),
    .rpt_ok   (smf_crc_ok),
    .ebit     (tx_ebit)
  );

  e1aa_freeze_ctl #(.MF_FRAMES(MF_FRAMES)) u_freeze (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (frm_stb),
    .los     (los),
    .cas_lma (cas_lma),
    .slip_evt(slip_evt),
    .dis     (c.freeze_dis),
    .trig    (freeze_trig),
    .freeze  (sig_freeze)
  );

  assert_trig_sets_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stb && freeze_trig && !c.freeze_dis) |=> sig_freeze);

endmodule

// File: tb/test_e1_auto_alarm.sv
module test_e1_auto_alarm;

  localparam int unsigned MFF = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_stb = 1'b0, tx_mf_start = 1'b0;
  logic       lfa = 1'b0, los = 1'b0, cas_lma = 1'b0, slip_evt = 1'b0;
  logic       smf_done = 1'b0, smf_idx = 1'b0, smf_crc_ok = 1'b1;
  logic [4:0] cfg = 5'b0;
  logic       tx_ra, ais_force, clk_master, sig_freeze;
  logic [1:0] tx_ebit;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  e1_auto_alarm #(.MF_FRAMES(MFF)) i_e1_auto_alarm (
    .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .tx_mf_start(tx_mf_start),
    .lfa(lfa), .los(los), .cas_lma(cas_lma), .slip_evt(slip_evt),
    .smf_done(smf_done), .smf_idx(smf_idx), .smf_crc_ok(smf_crc_ok),
    .cfg(cfg), .tx_ra(tx_ra), .tx_ebit(tx_ebit), .ais_force(ais_force),
    .clk_master(clk_master), .sig_freeze(sig_freeze)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one-cycle frame strobe; outputs sampled at the following negedge
  task automatic strobe(input logic mf);
    @(negedge clk);
    frm_stb = 1'b1; tx_mf_start = mf;
    @(negedge clk);
    frm_stb = 1'b0; tx_mf_start = 1'b0;
  endtask

  task automatic report(input logic idx, input logic ok);
    @(negedge clk);
    smf_done = 1'b1; smf_idx = idx; smf_crc_ok = ok;
    @(negedge clk);
    smf_done = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 reset tx_ra", tx_ra, 0);
    check("R10 reset tx_ebit", tx_ebit, 3);
    check("R10 reset ais_force", ais_force, 0);
    check("R10 reset clk_master", clk_master, 0);
    check("R10 reset sig_freeze", sig_freeze, 0);
  endtask

  task automatic t_remote_alarm;
    cfg = 5'b00001; lfa = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 no change without strobe", tx_ra, 0);
    strobe(1'b0);
    check("R1 ra set on lfa", tx_ra, 1);
    lfa = 1'b0;
    strobe(1'b0);
    check("R1 ra cleared on realign", tx_ra, 0);
    cfg = 5'b00000; lfa = 1'b1;
    strobe(1'b0);
    check("R1 ra off when disabled", tx_ra, 0);
    lfa = 1'b0; strobe(1'b0);
  endtask

  task automatic t_ais;
    cfg = 5'b00000; lfa = 1'b1;
    strobe(1'b0);
    check("R2 ais forced", ais_force, 1);
    cfg = 5'b00100;
    strobe(1'b0);
    check("R2 ais disabled", ais_force, 0);
    cfg = 5'b00000; lfa = 1'b0;
    strobe(1'b0);
    check("R2 ais released", ais_force, 0);
  endtask

  task automatic t_clock;
    cfg = 5'b10000; los = 1'b1;
    strobe(1'b0);
    check("R3 master on los", clk_master, 1);
    los = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 master held between strobes", clk_master, 1);
    strobe(1'b0);
    check("R3 slave after los", clk_master, 0);
    cfg = 5'b11000; los = 1'b1;
    strobe(1'b0);
    check("R3 switch disabled", clk_master, 0);
    los = 1'b0; cfg = 5'b00000;
    strobe(1'b0);
  endtask

  task automatic t_ebit;
    cfg = 5'b00010;
    strobe(1'b1);                 // flush anything pending
    report(1'b0, 1'b0);
    report(1'b1, 1'b1);
    strobe(1'b0);
    check("R4 ebit waits for mf start", tx_ebit, 3);
    strobe(1'b1);
    check("R4 ebit reports sent", tx_ebit, 2);
    strobe(1'b1);
    check("R4 empty slots send ones", tx_ebit, 3);
    report(1'b1, 1'b0);
    strobe(1'b1);
    check("R4 slot1 error only", tx_ebit, 1);
    cfg = 5'b00000;
    report(1'b0, 1'b0);
    strobe(1'b1);
    check("R5 disabled sends ones", tx_ebit, 3);
  endtask

  task automatic t_freeze;
    cfg = 5'b00000; los = 1'b1;
    strobe(1'b0);
    check("R6 freeze on los", sig_freeze, 1);
    los = 1'b0;
    for (int i = 0; i < MFF - 1; i++) strobe(1'b0);
    check("R8 freeze held one frame short", sig_freeze, 1);
    strobe(1'b0);
    check("R8 freeze released", sig_freeze, 0);
    cas_lma = 1'b1;
    strobe(1'b0);
    check("R6 freeze on cas_lma", sig_freeze, 1);
    cas_lma = 1'b0;
    for (int i = 0; i < 8; i++) strobe(1'b0);
    cas_lma = 1'b1; strobe(1'b0); cas_lma = 1'b0;
    for (int i = 0; i < MFF - 1; i++) strobe(1'b0);
    check("R8 count restarted by trigger", sig_freeze, 1);
    strobe(1'b0);
    check("R8 released after restart", sig_freeze, 0);
    @(negedge clk); slip_evt = 1'b1;
    @(negedge clk); slip_evt = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 slip waits for strobe", sig_freeze, 0);
    strobe(1'b0);
    check("R7 slip freezes", sig_freeze, 1);
    cfg = 5'b10000; los = 1'b1;
    strobe(1'b0);
    check("R9 freeze disabled", sig_freeze, 0);
    los = 1'b0; cfg = 5'b00000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_remote_alarm();
    t_ais();
    t_clock();
    t_ebit();
    t_freeze();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule